// File: doc/BRIEF.md
# Half-Duplex Serial Port Command Sequencer

This block is the host end of a synchronous two-wire serial link. It generates the serial clock and shares one bidirectional data line with the peripheral. A client hands it one command at a time: a 7-bit register address, a read/write flag and, for a write, a data byte. The block sends the frame MSB first. On a read it turns the data line around after the address byte and clocks the peripheral's reply back in. The reply comes out as a byte with a one-cycle valid strobe.

The peripheral needs minimum quiet times around commands. After a write, a long gap must pass before the edges that complete the next write or read. Inside a read, a long hold separates the address byte from the data byte. After a read, only a short gap is needed. The sequencer enforces these by keeping its ready output low until each command and its trailing gap are done. All delays are counted in system clock cycles and rounded up from nanosecond parameters.

After a read, the peripheral keeps driving its last data bit until the next falling edge of the serial clock. A separate request produces a timed high pulse on the power-down output, which makes the peripheral release the line.

Top module: `ser_cmd_seq`

## Requirements
- R1: After reset, and whenever idle, the block holds serial clock high, data output enable low, power-down low, read-valid low and ready high.
- R2: A command is accepted on a clock edge where ready and the command request are both high. It produces exactly 16 serial clock periods, each low for SCK_HALF cycles and then high for SCK_HALF cycles. The first 8 bits are the address byte {write flag, address[6:0]} and the next 8 are the write data, all MSB first. The data output changes only on falling serial clock edges while enabled.
- R3: In a write, the output enable stays high for all 16 bits. In a read, it drops after the high half of the 8th bit and stays low for the rest of the command. The host never drives while the peripheral drives.
- R4: In a read, the data input is sampled on each of the 8 data-phase rising edges, MSB first. The byte appears on the read data output with read-valid high for exactly one cycle, right after the high half of the last bit.
- R5: After a write is accepted, ready stays low for exactly 32*SCK_HALF + LONG cycles. LONG is ceil(LONG_GAP_NS * SYS_CLK_HZ / 1e9). The last data rising edge of a write and the completing rising edge of the next command are therefore at least LONG cycles apart.
- R6: In a read, at least LONG cycles separate the rising edge of the last address bit from the first data rising edge. Ready stays low for exactly 32*SCK_HALF + LONG + SHORT cycles, where SHORT is ceil(SHORT_GAP_NS * SYS_CLK_HZ / 1e9).
- R7: A power-down request taken while ready drives the power-down output high for exactly PD cycles, where PD is ceil(PD_NS * SYS_CLK_HZ / 1e9). Ready is low for those same cycles. The serial clock stays high and the output enable stays low during the pulse.
- R8: Command and power-down requests made while ready is low are ignored. They produce no extra frame and no pulse.
- R9: If a command request and a power-down request are both high on an accepting edge, the command is taken and the power-down request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_req_i | input | 1 | Command request |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 7 | Register address |
| cmd_wdata_i | input | 8 | Write data byte |
| cmd_rdy_o | output | 1 | High when a new request can be taken |
| rd_data_o | output | 8 | Byte returned by the last read |
| rd_valid_o | output | 1 | One-cycle strobe for rd_data_o |
| pd_req_i | input | 1 | Request for a power-down release pulse |
| pd_o | output | 1 | Power-down pin to the peripheral |
| sclk_o | output | 1 | Serial clock, idles high |
| sdio_o | output | 1 | Host data toward the shared line |
| sdio_oe_o | output | 1 | Tri-state enable for sdio_o |
| sdio_i | input | 1 | Data line as seen by the host |

## Verification
A bit counter or phase flag that slips shows on the first malformed frame: a 15th or 17th serial clock period, or an address byte shifted by one place. A bench model that captures every rising edge catches this by the end of that command. A wrong delay count shows as a ready-low stretch that differs from the exact formula in R5, R6 or R7. A wrong turnaround shows as the output enable overlapping the model's drive window inside the same read. A state machine that takes requests while busy shows as an extra frame or a stray power-down pulse within a few cycles of the ignored request.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP,
        ST_PDOWN
    } scs_state_e;

    typedef struct packed {
        scs_state_e state;
        logic [2:0] bitc;
        logic       hi;
        logic       dph;
        logic       wr;
        logic       sclk;
        logic       oe;
        logic       pd;
        logic       rvalid;
        logic [7:0] rdata;
        logic [7:0] wdata;
    } scs_reg_t;

    function automatic longint ns_to_cyc(longint ns, longint hz);
        longint c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/scs_dcount.sv
module scs_dcount #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scs_shreg.sv
module scs_shreg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         shift_i,
    input  logic         in_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = val_i;
        end else if (shift_i) begin
            sr_d = {sr_q[W-2:0], in_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    assign q_o = sr_q;
endmodule

// File: rtl/ser_cmd_seq.sv
module ser_cmd_seq
    import scs_pkg::*;
#(
    parameter int SYS_CLK_HZ   = 50_000_000,
    parameter int SCK_HALF     = 4,
    parameter int LONG_GAP_NS  = 100_000,
    parameter int SHORT_GAP_NS = 120,
    parameter int PD_NS        = 100_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cmd_req_i,
    input  logic       cmd_wr_i,
    input  logic [6:0] cmd_addr_i,
    input  logic [7:0] cmd_wdata_i,
    output logic       cmd_rdy_o,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o,
    input  logic       pd_req_i,
    output logic       pd_o,
    output logic       sclk_o,
    output logic       sdio_o,
    output logic       sdio_oe_o,
    input  logic       sdio_i
);
    localparam longint LONG_C  = ns_to_cyc(longint'(LONG_GAP_NS), longint'(SYS_CLK_HZ));
    localparam longint SHORT_C = ns_to_cyc(longint'(SHORT_GAP_NS), longint'(SYS_CLK_HZ));
    localparam longint PD_C    = ns_to_cyc(longint'(PD_NS), longint'(SYS_CLK_HZ));
    localparam longint HALF_C  = longint'(SCK_HALF);
    localparam longint MAX_A   = (LONG_C > SHORT_C) ? LONG_C : SHORT_C;
    localparam longint MAX_B   = (PD_C > HALF_C) ? PD_C : HALF_C;
    localparam longint MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int     CW      = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] HALF_LD  = CW'(HALF_C - 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_C - 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_C - 1);
    localparam logic [CW-1:0] PD_LD    = CW'(PD_C - 1);

    scs_reg_t r_d, r_q;

    logic          half_load, half_zero;
    logic          gap_load, gap_dec, gap_zero;
    logic [CW-1:0] gap_val;
    logic          sr_load, sr_shift, sr_in;
    logic [7:0]    sr_val, sr_q;

    scs_dcount #(.W(CW)) i_half (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (half_load),
        .val_i  (HALF_LD),
        .dec_i  (r_q.state == ST_SHIFT),
        .zero_o (half_zero)
    );

    scs_dcount #(.W(CW)) i_gap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (gap_load),
        .val_i  (gap_val),
        .dec_i  (gap_dec),
        .zero_o (gap_zero)
    );

    scs_shreg #(.W(8)) i_sr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (sr_load),
        .val_i   (sr_val),
        .shift_i (sr_shift),
        .in_i    (sr_in),
        .q_o     (sr_q)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rvalid = 1'b0;
        half_load = 1'b0;
        gap_load  = 1'b0;
        gap_val   = LONG_LD;
        gap_dec   = (r_q.state == ST_HOLD) || (r_q.state == ST_GAP) ||
                    (r_q.state == ST_PDOWN);
        sr_load   = 1'b0;
        sr_val    = {cmd_wr_i, cmd_addr_i};
        sr_shift  = 1'b0;
        sr_in     = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_req_i) begin
                    r_d.state = ST_SHIFT;
                    r_d.wr    = cmd_wr_i;
                    r_d.wdata = cmd_wdata_i;
                    r_d.dph   = 1'b0;
                    r_d.bitc  = '0;
                    r_d.hi    = 1'b0;
                    r_d.sclk  = 1'b0;
                    r_d.oe    = 1'b1;
                    sr_load   = 1'b1;
                    half_load = 1'b1;
                end else if (pd_req_i) begin
                    r_d.state = ST_PDOWN;
                    r_d.pd    = 1'b1;
                    gap_load  = 1'b1;
                    gap_val   = PD_LD;
                end
            end
            ST_SHIFT: begin
                if (half_zero) begin
                    half_load = 1'b1;
                    if (!r_q.hi) begin
                        r_d.hi   = 1'b1;
                        r_d.sclk = 1'b1;
                        if (r_q.dph && !r_q.wr) begin
                            sr_shift = 1'b1;
                            sr_in    = sdio_i;
                        end
                    end else if (r_q.bitc == 3'd7) begin
                        if (!r_q.dph && r_q.wr) begin
                            r_d.dph  = 1'b1;
                            r_d.bitc = '0;
                            r_d.hi   = 1'b0;
                            r_d.sclk = 1'b0;
                            sr_load  = 1'b1;
                            sr_val   = r_q.wdata;
                        end else if (!r_q.dph) begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_HOLD;
                            gap_load  = 1'b1;
                            gap_val   = LONG_LD;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_GAP;
                            gap_load  = 1'b1;
                            gap_val   = r_q.wr ? LONG_LD : SHORT_LD;
                            if (!r_q.wr) begin
                                r_d.rdata  = sr_q;
                                r_d.rvalid = 1'b1;
                            end
                        end
                    end else begin
                        r_d.bitc = r_q.bitc + 3'd1;
                        r_d.hi   = 1'b0;
                        r_d.sclk = 1'b0;
                        if (!r_q.dph || r_q.wr) begin
                            sr_shift = 1'b1;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (gap_zero) begin
                    r_d.state = ST_SHIFT;
                    r_d.dph   = 1'b1;
                    r_d.bitc  = '0;
                    r_d.hi    = 1'b0;
                    r_d.sclk  = 1'b0;
                    half_load = 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_zero) r_d.state = ST_IDLE;
            end
            ST_PDOWN: begin
                if (gap_zero) begin
                    r_d.state = ST_IDLE;
                    r_d.pd    = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.sclk  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_rdy_o  = (r_q.state == ST_IDLE);
    assign rd_data_o  = r_q.rdata;
    assign rd_valid_o = r_q.rvalid;
    assign pd_o       = r_q.pd;
    assign sclk_o     = r_q.sclk;
    assign sdio_oe_o  = r_q.oe;
    assign sdio_o     = r_q.oe & sr_q[7];
endmodule

// File: rtl/scs_chk.sv
module scs_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cmd_req_i,
    input logic pd_req_i,
    input logic cmd_rdy_o,
    input logic rd_valid_o,
    input logic pd_o,
    input logic sclk_o,
    input logic sdio_o,
    input logic sdio_oe_o
);
    // R1
    idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_rdy_o |-> (sclk_o && !sdio_oe_o && !pd_o));

    // R2
    sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sdio_oe_o && $past(sdio_oe_o) && !$stable(sdio_o)) |-> $fell(sclk_o));

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |=> !rd_valid_o);

    // R3
    rvalid_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> (!sdio_oe_o && sclk_o));

    // R7
    pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_o |-> (!sdio_oe_o && sclk_o && !cmd_rdy_o));

    // R7
    pd_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pd_o) |-> ($past(cmd_rdy_o) && $past(pd_req_i) && !$past(cmd_req_i)));

    // R8
    busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cmd_rdy_o) |-> ($past(cmd_req_i) || $past(pd_req_i)));

    // R9
    cmd_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_rdy_o && cmd_req_i && pd_req_i) |=> !pd_o);
endmodule

bind ser_cmd_seq scs_chk i_scs_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_req_i  (cmd_req_i),
    .pd_req_i   (pd_req_i),
    .cmd_rdy_o  (cmd_rdy_o),
    .rd_valid_o (rd_valid_o),
    .pd_o       (pd_o),
    .sclk_o     (sclk_o),
    .sdio_o     (sdio_o),
    .sdio_oe_o  (sdio_oe_o)
);

// File: tb/test_ser_cmd_seq.sv
module test_ser_cmd_seq;
    localparam int H       = 4;
    localparam int LONG_C  = 100;   // 2000 ns at 50 MHz
    localparam int SHORT_C = 7;     // 130 ns at 50 MHz rounds up to 7
    localparam int PD_C    = 50;    // 1000 ns at 50 MHz
    localparam int WR_BUSY = 32 * H + LONG_C;
    localparam int RD_BUSY = 32 * H + LONG_C + SHORT_C;

    // {write flag, address[6:0], data[7:0]}
    localparam logic [15:0] VEC [7] = '{
        16'h8A5C, 16'hC0FF, 16'h1200, 16'hFF00,
        16'h7F00, 16'h0100, 16'hAA55
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_req = 1'b0, cmd_wr = 1'b0, pd_req = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_rdy, rd_valid, pd, sclk, sdo, sdo_oe;
    logic [7:0] rd_data;
    logic       sdi;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    longint cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ser_cmd_seq #(
        .SYS_CLK_HZ(50_000_000), .SCK_HALF(H), .LONG_GAP_NS(2000),
        .SHORT_GAP_NS(130), .PD_NS(1000)
    ) i_ser_cmd_seq (
        .clk_i(clk), .rst_ni(rst_n), .cmd_req_i(cmd_req), .cmd_wr_i(cmd_wr),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_rdy_o(cmd_rdy),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .pd_req_i(pd_req),
        .pd_o(pd), .sclk_o(sclk), .sdio_o(sdo), .sdio_oe_o(sdo_oe),
        .sdio_i(sdi)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Peripheral model
    int          rise_n = 0;
    int          frames = 0;
    logic [15:0] cap = '0, last_frame = '0;
    logic [7:0]  resp = '0;
    logic        cur_wr = 1'b0, drv = 1'b0, drv_bit = 1'b0;
    int          prev_kind = 0;
    longint      prev_w_end = 0, addr_rise = 0;
    int          contention = 0;

    assign sdi = drv ? drv_bit : 1'b0;

    always @(posedge sclk) begin
        if (rst_n) begin
            cap = {cap[14:0], sdo};
            rise_n++;
            if (rise_n == 8) begin
                cur_wr    = cap[7];
                addr_rise = cyc;
                resp      = cap[7:0] ^ 8'hC3;
                if (!cur_wr && prev_kind == 1)
                    chk(cyc - prev_w_end >= LONG_C, "R5 write-to-read gap", cyc - prev_w_end, LONG_C);
            end
            if (rise_n == 9 && !cur_wr)
                chk(cyc - addr_rise >= LONG_C, "R6 read hold", cyc - addr_rise, LONG_C);
            if (rise_n == 16) begin
                if (cur_wr && prev_kind == 1)
                    chk(cyc - prev_w_end >= LONG_C, "R5 write-to-write gap", cyc - prev_w_end, LONG_C);
                prev_kind = cur_wr ? 1 : 2;
                if (cur_wr) prev_w_end = cyc;
                last_frame = cap;
                frames++;
                rise_n = 0;
            end
        end
    end

    always @(negedge sclk or posedge pd) begin
        if (pd) begin
            drv = 1'b0;
        end else if (rise_n >= 8 && !cur_wr) begin
            drv     = 1'b1;
            drv_bit = resp[15 - rise_n];
        end else begin
            drv = 1'b0;
        end
    end

    always @(negedge clk) if (rst_n && drv && sdo_oe) contention++;

    // inj: 0 none, 1 pd pulse while busy, 2 cmd pulse while busy, 3 pd with cmd
    task automatic run_cmd(input logic wr, input logic [6:0] a, input logic [7:0] d,
                           input int inj, output int busy, output int vcnt,
                           output logic [7:0] rd, output int pd_hi);
        busy = 0; vcnt = 0; rd = '0; pd_hi = 0;
        while (!cmd_rdy) @(negedge clk);
        cmd_wr = wr; cmd_addr = a; cmd_wdata = d; cmd_req = 1'b1;
        if (inj == 3) pd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0; pd_req = 1'b0;
        while (!cmd_rdy) begin
            busy++;
            if (rd_valid) begin vcnt++; rd = rd_data; end
            if (pd) pd_hi++;
            if (busy == 10 && inj == 1) pd_req = 1'b1;
            if (busy == 10 && inj == 2) begin
                cmd_req = 1'b1; cmd_wr = 1'b1; cmd_addr = 7'h33; cmd_wdata = 8'hEE;
            end
            if (busy == 11) begin pd_req = 1'b0; cmd_req = 1'b0; end
            @(negedge clk);
        end
        if (pd) pd_hi++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int busy, vc, phi, fr0;
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_rdy && sclk && !sdo_oe && !pd && !rd_valid, "R1 reset state",
            {cmd_rdy, sclk, sdo_oe, pd, rd_valid}, 5'b11000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd_rdy && sclk && !sdo_oe && !pd, "R1 idle after reset",
            {cmd_rdy, sclk, sdo_oe, pd}, 4'b1100);

        for (int i = 0; i < 7; i++) begin
            logic [15:0] v;
            v = VEC[i];
            fr0 = frames;
            run_cmd(v[15], v[14:8], v[7:0], 0, busy, vc, rd, phi);
            chk(frames == fr0 + 1, "R2 one frame per command", frames - fr0, 1);
            if (v[15]) begin
                chk(last_frame == v, "R2 write frame bits", last_frame, v);
                chk(busy == WR_BUSY, "R5 write busy length", busy, WR_BUSY);
                chk(vc == 0, "R4 no valid on write", vc, 0);
            end else begin
                chk(last_frame[15:8] == v[15:8], "R2 read address byte", last_frame[15:8], v[15:8]);
                chk(busy == RD_BUSY, "R6 read busy length", busy, RD_BUSY);
                chk(vc == 1, "R4 single valid strobe", vc, 1);
                chk(rd == ({1'b0, v[14:8]} ^ 8'hC3), "R4 read data", rd, {1'b0, v[14:8]} ^ 8'hC3);
            end
        end

        // R7: release a line held after a read
        run_cmd(1'b0, 7'h25, 8'h00, 0, busy, vc, rd, phi);
        chk(drv == 1'b1, "R7 line held after read", drv, 1);
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        pd_req = 1'b0;
        busy = 0; phi = 0;
        while (!cmd_rdy) begin busy++; if (pd) phi++; @(negedge clk); end
        chk(phi == PD_C, "R7 pd pulse length", phi, PD_C);
        chk(busy == PD_C, "R7 ready low during pulse", busy, PD_C);
        chk(!pd && drv == 1'b0, "R7 line released", {pd, drv}, 0);

        // R8: pd request while busy is ignored
        run_cmd(1'b1, 7'h11, 8'h22, 1, busy, vc, rd, phi);
        repeat (3) @(negedge clk);
        chk(phi == 0 && !pd && cmd_rdy, "R8 pd ignored while busy", phi, 0);

        // R8: command request while busy is ignored
        fr0 = frames;
        run_cmd(1'b1, 7'h44, 8'h99, 2, busy, vc, rd, phi);
        repeat (5) @(negedge clk);
        chk(frames == fr0 + 1 && cmd_rdy, "R8 cmd ignored while busy", frames - fr0, 1);
        chk(last_frame == 16'hC499, "R8 frame of accepted cmd", last_frame, 16'hC499);

        // R9: simultaneous requests, command wins
        fr0 = frames;
        run_cmd(1'b1, 7'h05, 8'h3C, 3, busy, vc, rd, phi);
        chk(phi == 0 && frames == fr0 + 1, "R9 command wins", phi, 0);
        chk(busy == WR_BUSY, "R9 busy is a write", busy, WR_BUSY);

        // R3: never drive against the peripheral
        chk(contention == 0, "R3 no contention", contention, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule